// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block records when an external tamper or event line fires. It watches an active-low event input that is normally driven by a mechanical push button. It brings the input into the clock domain, filters contact bounce at a 16 Hz sample rate and reacts only to an accepted high-to-low transition. On that transition it freezes a copy of the running calendar. The copy holds the sub-second count in sixteenths together with seconds, minutes, hours, day, month and year, all in BCD.

The frozen copy stays put while a sticky event flag is set. Software reads the fields through a small address/data read port, then clears the flag with a one-cycle strobe, which re-arms the unit. An active-low interrupt line is driven low whenever the flag is set and interrupts are enabled.

Top module: `tamper_snap`

## Requirements
- R1: After reset the event flag is 0, irqN is 1, and every read address returns 8'h00.
- R2: The event input is active low. While evtN stays high, no capture occurs and the flag stays 0.
- R3: A change of the event level is accepted only after DEB_SAMPLES (default 3) consecutive 16 Hz tick samples of the synchronised input all show the new level. A low pulse covering only 2 ticks is ignored.
- R4: Only an accepted high-to-low transition triggers a capture. Holding the input low, or an accepted low-to-high transition, triggers no capture, even after the flag has been cleared.
- R5: A capture stores the calendar inputs present at the clock edge of the accepting tick. The sixteenths field (0 to 15) occupies the low nibble of its read byte.
- R6: All seven fields are stored in the same clock cycle. A calendar rollover that happens right after the capture does not alter any stored field.
- R7: A capture sets the sticky flag. While the flag is set, further accepted events leave the stored fields unchanged.
- R8: A one-cycle clrFlag pulse clears the flag, and the next accepted falling transition captures new values.
- R9: irqN is 0 exactly when the flag is 1 and irqEn is 1, and is 1 otherwise.
- R10: Read map on rdAddr: 0 = {4'h0, sixteenths}, 1 = seconds, 2 = minutes, 3 = hours, 4 = day, 5 = month, 6 = year, 7 = {7'b0, flag}. rdData is combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle 16 Hz sampling pulse |
| evtN | input | 1 | Raw active-low event input |
| calSub | input | 4 | Running sixteenths-of-second count |
| calSec | input | 8 | Running seconds, BCD |
| calMin | input | 8 | Running minutes, BCD |
| calHour | input | 8 | Running hours, BCD |
| calDay | input | 8 | Running day of month, BCD |
| calMon | input | 8 | Running month, BCD |
| calYear | input | 8 | Running year, BCD |
| clrFlag | input | 1 | One-cycle pulse that clears the event flag |
| irqEn | input | 1 | Interrupt enable |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data |
| evtFlag | output | 1 | Sticky event flag |
| irqN | output | 1 | Active-low interrupt request |

## Verification
On every cycle, the assertions check four things. The filtered level changes only on a tick. A capture always leaves the flag set. The flag persists until it is cleared. The stored fields never move except on a capture strobe. The bench scenarios cover the rest. These are the rejection of a two-tick bounce, the absence of a recapture while the button is held down or released, the protection of the stored fields while the flag is set, and the coherence of all seven fields across a calendar rollover. Each of these can only be shown by comparing read-back values against the calendar the bench drove.

// File: rtl/tamper_snap_pkg.sv
package tamper_snap_pkg;
  localparam int SUB_W = 4;
  localparam int BCD_W = 8;
  localparam int ADDR_W = 3;

  typedef struct packed {
    logic [SUB_W-1:0] sub;
    logic [BCD_W-1:0] sec;
    logic [BCD_W-1:0] min;
    logic [BCD_W-1:0] hour;
    logic [BCD_W-1:0] day;
    logic [BCD_W-1:0] mon;
    logic [BCD_W-1:0] year;
  } calSnap_t;

  typedef struct packed {
    logic capture;
  } snapStrobe_t;
endpackage

// File: rtl/tamper_snap_ctrl.sv
module tamper_snap_ctrl
  import tamper_snap_pkg::*;
#(
  parameter int DEB_SAMPLES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick16,
  input  logic        evtN,
  input  logic        clrFlag,
  input  logic        irqEn,
  output snapStrobe_t strobe,
  output logic        evtFlag,
  output logic        irqN
);
  localparam int CNT_W = $clog2(DEB_SAMPLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_SAMPLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic syncLvl;
  logic stableLvl;
  logic [CNT_W-1:0] agreeCnt;
  logic acceptFall;
  logic flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], evtN};
  end
  assign syncLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableLvl <= 1'b1;
      agreeCnt  <= '0;
    end else if (tick16) begin
      if (syncLvl == stableLvl) begin
        agreeCnt <= '0;
      end else if (agreeCnt == LAST) begin
        stableLvl <= syncLvl;
        agreeCnt  <= '0;
      end else begin
        agreeCnt <= agreeCnt + 1'b1;
      end
    end
  end

  assign acceptFall     = tick16 && stableLvl && !syncLvl && (agreeCnt == LAST);
  assign strobe.capture = acceptFall && !flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               flagQ <= 1'b0;
    else if (strobe.capture) flagQ <= 1'b1;
    else if (clrFlag)        flagQ <= 1'b0;
  end

  assign evtFlag = flagQ;
  assign irqN    = !(flagQ && irqEn);

  a_r3_level_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (stableLvl != $past(stableLvl)) |-> $past(tick16));
  a_r7_capture_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> evtFlag);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (evtFlag && !clrFlag) |=> evtFlag);
  a_r4_single_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !strobe.capture);
endmodule

// File: rtl/tamper_snap_dp.sv
module tamper_snap_dp
  import tamper_snap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  snapStrobe_t       strobe,
  input  calSnap_t          calNow,
  input  logic              evtFlag,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BCD_W-1:0]  rdData
);
  calSnap_t snapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               snapQ <= '0;
    else if (strobe.capture) snapQ <= calNow;
  end

  always_comb begin
    unique case (rdAddr)
      3'd0:    rdData = {{(BCD_W-SUB_W){1'b0}}, snapQ.sub};
      3'd1:    rdData = snapQ.sec;
      3'd2:    rdData = snapQ.min;
      3'd3:    rdData = snapQ.hour;
      3'd4:    rdData = snapQ.day;
      3'd5:    rdData = snapQ.mon;
      3'd6:    rdData = snapQ.year;
      default: rdData = {{(BCD_W-1){1'b0}}, evtFlag};
    endcase
  end

  a_r6_hold_between_captures: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(snapQ));
endmodule

// File: rtl/tamper_snap.sv
module tamper_snap
  import tamper_snap_pkg::*;
#(
  parameter int DEB_SAMPLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              evtN,
  input  logic [SUB_W-1:0]  calSub,
  input  logic [BCD_W-1:0]  calSec,
  input  logic [BCD_W-1:0]  calMin,
  input  logic [BCD_W-1:0]  calHour,
  input  logic [BCD_W-1:0]  calDay,
  input  logic [BCD_W-1:0]  calMon,
  input  logic [BCD_W-1:0]  calYear,
  input  logic              clrFlag,
  input  logic              irqEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BCD_W-1:0]  rdData,
  output logic              evtFlag,
  output logic              irqN
);
  snapStrobe_t strobe;
  calSnap_t    calNow;

  assign calNow = '{sub: calSub, sec: calSec, min: calMin, hour: calHour,
                    day: calDay, mon: calMon, year: calYear};

  tamper_snap_ctrl #(.DEB_SAMPLES(DEB_SAMPLES), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .evtN(evtN),
    .clrFlag(clrFlag), .irqEn(irqEn), .strobe(strobe),
    .evtFlag(evtFlag), .irqN(irqN)
  );

  tamper_snap_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .calNow(calNow),
    .evtFlag(evtFlag), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/tamper_snap_bench.sv
`timescale 1ns/1ps
module tamper_snap_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic evtN = 1'b1;
  logic [3:0] calSub = '0;
  logic [7:0] calSec = '0, calMin = '0, calHour = '0, calDay = '0, calMon = '0, calYear = '0;
  logic clrFlag = 1'b0;
  logic irqEn = 1'b0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic evtFlag, irqN;

  int nCmp = 0;
  int nBad = 0;
  bit busy = 0;

  typedef struct {
    logic [2:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  tamper_snap u_tamper_snap (
    .clk(clk), .rstN(rstN), .tick16(tick16), .evtN(evtN),
    .calSub(calSub), .calSec(calSec), .calMin(calMin), .calHour(calHour),
    .calDay(calDay), .calMon(calMon), .calYear(calYear),
    .clrFlag(clrFlag), .irqEn(irqEn), .rdAddr(rdAddr),
    .rdData(rdData), .evtFlag(evtFlag), .irqN(irqN)
  );

  // monitor: pops expected items and compares the read port
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        busy = 1;
        it = q.pop_front();
        rdAddr = it.addr;
        #1;
        nCmp++;
        if (rdData !== it.exp) begin
          nBad++;
          $display("FAIL %s addr %0d: actual %h expected %h", it.tag, it.addr, rdData, it.exp);
        end
        busy = 0;
      end
    end
  end

  task automatic expectRd(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    while (q.size() > 0 || busy) @(negedge clk);
  endtask

  task automatic expectSnap(input logic [3:0] s, input logic [7:0] se, mi, ho, dy, mo, yr,
                            input string tag);
    expectRd(3'd0, {4'h0, s}, tag);
    expectRd(3'd1, se, tag);
    expectRd(3'd2, mi, tag);
    expectRd(3'd3, ho, tag);
    expectRd(3'd4, dy, tag);
    expectRd(3'd5, mo, tag);
    expectRd(3'd6, yr, tag);
    drain();
  endtask

  task automatic checkBit(input logic act, input logic exp, input string tag);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    repeat (3) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic setCal(input logic [3:0] s, input logic [7:0] se, mi, ho, dy, mo, yr);
    calSub = s; calSec = se; calMin = mi; calHour = ho; calDay = dy; calMon = mo; calYear = yr;
  endtask

  task automatic press();
    evtN = 1'b0;
    repeat (3) tick();
  endtask

  task automatic release_();
    evtN = 1'b1;
    repeat (3) tick();
  endtask

  task automatic clearFlag();
    @(negedge clk); clrFlag = 1'b1;
    @(negedge clk); clrFlag = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) expectRd(3'(a), 8'h00, "R1 reset read");
    drain();
    checkBit(evtFlag, 1'b0, "R1 flag");
    checkBit(irqN, 1'b1, "R1 irqN");

    // R2 idle high: no capture
    setCal(4'd3, 8'h11, 8'h22, 8'h05, 8'h14, 8'h07, 8'h23);
    irqEn = 1'b1;
    repeat (6) tick();
    checkBit(evtFlag, 1'b0, "R2 idle flag");
    checkBit(irqN, 1'b1, "R2 idle irqN");

    // R3 two-tick bounce ignored
    evtN = 1'b0;
    repeat (2) tick();
    evtN = 1'b1;
    repeat (3) tick();
    checkBit(evtFlag, 1'b0, "R3 bounce flag");
    expectRd(3'd1, 8'h00, "R3 bounce sec");
    drain();

    // R5 capture on third low sample
    irqEn = 1'b0;
    setCal(4'd9, 8'h37, 8'h42, 8'h13, 8'h28, 8'h02, 8'h24);
    press();
    checkBit(evtFlag, 1'b1, "R7 flag set");
    expectSnap(4'd9, 8'h37, 8'h42, 8'h13, 8'h28, 8'h02, 8'h24, "R5 capture");
    expectRd(3'd7, 8'h01, "R10 flag read");
    drain();

    // R9 interrupt gating
    checkBit(irqN, 1'b1, "R9 irq disabled");
    irqEn = 1'b1;
    #1 checkBit(irqN, 1'b0, "R9 irq enabled");

    // R4 hold low after clear: no recapture; release: no capture
    clearFlag();
    checkBit(irqN, 1'b1, "R9 irq after clear");
    setCal(4'd1, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01);
    repeat (4) tick();
    checkBit(evtFlag, 1'b0, "R4 held low");
    release_();
    checkBit(evtFlag, 1'b0, "R4 rising edge");

    // R8 new capture after clear
    setCal(4'd15, 8'h59, 8'h08, 8'h20, 8'h09, 8'h11, 8'h30);
    press();
    checkBit(evtFlag, 1'b1, "R8 flag");
    checkBit(irqN, 1'b0, "R9 irq on capture");
    expectSnap(4'd15, 8'h59, 8'h08, 8'h20, 8'h09, 8'h11, 8'h30, "R8 recapture");

    // R7 second event with flag set does not overwrite
    release_();
    setCal(4'd4, 8'h44, 8'h44, 8'h04, 8'h04, 8'h04, 8'h44);
    press();
    expectSnap(4'd15, 8'h59, 8'h08, 8'h20, 8'h09, 8'h11, 8'h30, "R7 no overwrite");
    checkBit(evtFlag, 1'b1, "R7 flag kept");

    // R6 rollover right after capture
    clearFlag();
    release_();
    setCal(4'd15, 8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
    press();
    setCal(4'd0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    tick();
    expectSnap(4'd15, 8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, "R6 rollover");
    expectRd(3'd7, 8'h01, "R10 flag read end");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule